// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. A free-running timebase counter gives software a way to see that the clock is alive. A separate interval counter measures how long it has been since software last serviced the watchdog. The interval counter only advances while two enable bits, held in two different registers, are both set. When a full interval elapses without service, the watchdog first raises a state flag and a level interrupt. If a second interval then elapses while that flag is still set, the watchdog requests a system reset and records that it did so.

Software services the watchdog by writing ones to the state and reset-status bits of the first control register. This clears them and starts the interval again. Three elaboration options shape the block. The interval length is a power of two set by an exponent. The reset request can be a one-cycle pulse or a level held until the next system reset. An enable-once option, when chosen, stops software from clearing the enable bits once the watchdog has started.

Top module: `twostage_wdt`

## Requirements
- R1: Register words are selected by `bus_addr[ADDR_W-1:2]`: word 0 is the first control register, word 1 the second, and word 2 the timebase. Read data is combinational from the address. Reads of any other word return zero, and writes to any other word change no state.
- R2: Control word 0 reads as bit 3 = reset-status flag, bit 2 = state flag, bit 1 = enable A, and bit 0 = a read-only copy of enable B. Control word 1 holds enable B in bit 0. Writes to word 0 load enable A from bit 1, and bit 0 of such a write is ignored. All bits not named here read as zero.
- R3: The interval counter runs only while enable A and enable B are both set, and it is held at zero otherwise. An expiry happens after 2^INTERVAL_EXP consecutive running cycles that contain no service write.
- R4: An expiry while the state flag is clear sets the state flag. `irq_o` is high exactly while the state flag is set.
- R5: An expiry while the state flag is set sets the reset-status flag and asserts `wdt_rst_o` on the same clock edge.
- R6: A write to word 0 clears the state flag if bit 2 is one and clears the reset-status flag if bit 3 is one. If either of those bits is one, the interval restarts from zero. A service write on the same edge as a pending expiry wins, and no expiry occurs.
- R7: The timebase word increments by one on every clock edge after reset, whatever the enables are. Writes to it have no effect.
- R8: With RST_HOLD = 0, `wdt_rst_o` is high for exactly one cycle per reset-raising expiry. With RST_HOLD = 1, it stays high until `rst_n` is asserted. The reset-status flag stays set after the request until software or `rst_n` clears it.
- R9: With ENABLE_ONCE = 1, once both enables have been seen set together, writes can no longer clear either enable. With ENABLE_ONCE = 0, writes of zero clear them.
- R10: While `rst_n` is low and right after it is released, all flags, enables and both outputs are zero, and the timebase reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Level interrupt, high while the state flag is set |
| wdt_rst_o | output | 1 | System reset request |

## Verification
On every cycle the assertions check these properties: the interval counter stays cleared while the watchdog is not running, the timebase never stands still, a reset request only follows a set state flag, the pulse or hold shape of the request, and that locked enables stay set. The exact timing of the expiries and the outcome of a service write that meets an expiry on the same edge can only be seen by scenarios. The same holds for the contrast between the two reset-output variants and between enable-once and free enables under the same write sequence. The bench therefore drives two instances with opposite options from one bus.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned WORD_CTRLA = 0;
   localparam int unsigned WORD_CTRLB = 1;
   localparam int unsigned WORD_TBASE = 2;
   localparam int unsigned BIT_RSTAT  = 3;
   localparam int unsigned BIT_STATE  = 2;
   localparam int unsigned BIT_ENA    = 1;
   localparam int unsigned BIT_ENB    = 0;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
   parameter int unsigned TB_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TB_W-1:0] tb_o
);
   logic [TB_W-1:0] tb_q;
   logic            vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_q  <= '0;
         vld_q <= 1'b0;
      end else begin
         tb_q  <= tb_q + 1'b1;
         vld_q <= 1'b1;
      end
   end

   assign tb_o = tb_q;

   assert_tb_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (tb_q != $past(tb_q)));
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
   parameter int unsigned INTERVAL_EXP = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam logic [INTERVAL_EXP-1:0] LAST = '1;

   logic [INTERVAL_EXP-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!run_i || restart_i) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i && (cnt_q == LAST) && !restart_i;

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
   parameter bit RST_HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic clr_state_i,
   input  logic clr_rstat_i,
   output logic state_o,
   output logic rstat_o,
   output logic rst_o
);
   logic state_q;
   logic rstat_q;
   logic rst_q;
   logic fire;

   assign fire = expire_i && state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         rstat_q <= 1'b0;
      end else begin
         if (clr_state_i)   state_q <= 1'b0;
         else if (expire_i) state_q <= 1'b1;
         if (clr_rstat_i)   rstat_q <= 1'b0;
         else if (fire)     rstat_q <= 1'b1;
      end
   end

   generate
      if (RST_HOLD) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= rst_q | fire;
         end
         assert_rst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rst_q |=> rst_q);
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= fire;
         end
         assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rst_q |=> !rst_q);
      end
   endgenerate

   assign state_o = state_q;
   assign rstat_o = rstat_q;
   assign rst_o   = rst_q;

   assert_rst_after_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> $past(state_q));
   assert_rstat_with_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rstat_q) |-> rst_q);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter bit          ENABLE_ONCE = 1'b0,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned TB_W        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              state_i,
   input  logic              rstat_i,
   input  logic [TB_W-1:0]   tb_i,
   output logic              ena_o,
   output logic              enb_o,
   output logic              clr_state_o,
   output logic              clr_rstat_o,
   output logic              restart_o
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] widx;
   logic              hit_a;
   logic              hit_b;
   logic              lock;
   logic              ena_q;
   logic              enb_q;
   logic [DATA_W-1:0] tb_ext;
   logic              unused_bits;

   assign widx        = bus_addr[ADDR_W-1:2];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:4]};
   assign hit_a       = bus_wr && (widx == WIDX_W'(WORD_CTRLA));
   assign hit_b       = bus_wr && (widx == WIDX_W'(WORD_CTRLB));

   assign clr_state_o = hit_a && bus_wdata[BIT_STATE];
   assign clr_rstat_o = hit_a && bus_wdata[BIT_RSTAT];
   assign restart_o   = clr_state_o || clr_rstat_o;

   generate
      if (ENABLE_ONCE) begin : g_once
         logic started_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) started_q <= 1'b0;
            else        started_q <= started_q | (ena_q & enb_q);
         end
         assign lock = started_q;
         assert_lock_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && ena_q) |=> ena_q);
         assert_lock_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && enb_q) |=> enb_q);
      end else begin : g_free
         assign lock = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= 1'b0;
         enb_q <= 1'b0;
      end else begin
         if (hit_a) ena_q <= bus_wdata[BIT_ENA] | (lock & ena_q);
         if (hit_b) enb_q <= bus_wdata[BIT_ENB] | (lock & enb_q);
      end
   end

   generate
      if (TB_W < DATA_W) begin : g_tb_pad
         assign tb_ext = {{(DATA_W-TB_W){1'b0}}, tb_i};
      end else begin : g_tb_full
         assign tb_ext = tb_i;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (widx)
         WIDX_W'(WORD_CTRLA): begin
            bus_rdata[BIT_RSTAT] = rstat_i;
            bus_rdata[BIT_STATE] = state_i;
            bus_rdata[BIT_ENA]   = ena_q;
            bus_rdata[BIT_ENB]   = enb_q;
         end
         WIDX_W'(WORD_CTRLB): bus_rdata[BIT_ENB] = enb_q;
         WIDX_W'(WORD_TBASE): bus_rdata = tb_ext;
         default: bus_rdata = '0;
      endcase
   end

   assign ena_o = ena_q;
   assign enb_o = enb_q;
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
   import wdt_pkg::*;
#(
   parameter int unsigned INTERVAL_EXP = 16,
   parameter int unsigned TB_W         = 32,
   parameter int unsigned ADDR_W       = 4,
   parameter bit          ENABLE_ONCE  = 1'b0,
   parameter bit          RST_HOLD     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              wdt_rst_o
);
   generate
      if (INTERVAL_EXP < 1 || INTERVAL_EXP > 31) begin : g_bad_exp
         $error("INTERVAL_EXP must lie in 1..31");
      end
      if (TB_W < 2 || TB_W > DATA_W) begin : g_bad_tb
         $error("TB_W must lie in 2..32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must be at least 4 to reach the timebase word");
      end
   endgenerate

   logic [TB_W-1:0] tb;
   logic ena, enb, run, restart, expire;
   logic clr_state, clr_rstat, state, rstat;

   assign run = ena & enb;

   wdt_timebase #(.TB_W(TB_W)) u_tbase (
      .clk (clk), .rst_n (rst_n), .tb_o (tb)
   );

   wdt_interval #(.INTERVAL_EXP(INTERVAL_EXP)) u_ivl (
      .clk (clk), .rst_n (rst_n), .run_i (run),
      .restart_i (restart), .expire_o (expire)
   );

   wdt_stage #(.RST_HOLD(RST_HOLD)) u_stage (
      .clk (clk), .rst_n (rst_n), .expire_i (expire),
      .clr_state_i (clr_state), .clr_rstat_i (clr_rstat),
      .state_o (state), .rstat_o (rstat), .rst_o (wdt_rst_o)
   );

   wdt_regs #(.ENABLE_ONCE(ENABLE_ONCE), .ADDR_W(ADDR_W), .TB_W(TB_W)) u_regs (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .state_i (state), .rstat_i (rstat), .tb_i (tb),
      .ena_o (ena), .enb_o (enb), .clr_state_o (clr_state),
      .clr_rstat_o (clr_rstat), .restart_o (restart)
   );

   assign irq_o = state;

   assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(run));
endmodule

// File: tb/sim_twostage_wdt.sv
module sim_twostage_wdt;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int EXP  = 4;
   localparam int LAST = (1 << EXP) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd0, rd1;
   logic        irq0, irq1, rst0, rst1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   twostage_wdt #(.INTERVAL_EXP(EXP), .TB_W(32), .ADDR_W(4),
                  .ENABLE_ONCE(1'b0), .RST_HOLD(1'b0)) u0 (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (rd0), .irq_o (irq0), .wdt_rst_o (rst0));

   twostage_wdt #(.INTERVAL_EXP(EXP), .TB_W(32), .ADDR_W(4),
                  .ENABLE_ONCE(1'b1), .RST_HOLD(1'b1)) u1 (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (rd1), .irq_o (irq1), .wdt_rst_o (rst1));

   // Behavioural reference: index 0 = free enables + pulse, index 1 = enable-once + hold
   int          m_cnt[2];
   bit          m_ena[2], m_enb[2], m_wds[2], m_wrs[2], m_rst[2], m_start[2];
   logic [31:0] m_tb;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tb = 0;
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_ena[i] = 0; m_enb[i] = 0; m_wds[i] = 0;
            m_wrs[i] = 0; m_rst[i] = 0; m_start[i] = 0;
         end
      end else begin
         int  word;
         bit  wa, wb, svc, run, expire, fire, lock;
         word = int'(bus_addr) / 4;
         wa   = bus_wr && word == 0;
         wb   = bus_wr && word == 1;
         svc  = wa && (bus_wdata[3] || bus_wdata[2]);
         m_tb = m_tb + 1;
         for (int i = 0; i < 2; i++) begin
            run    = m_ena[i] && m_enb[i];
            lock   = (i == 1) && m_start[i];
            expire = run && m_cnt[i] == LAST && !svc;
            fire   = expire && m_wds[i];
            if (wa && bus_wdata[3]) m_wrs[i] = 0; else if (fire) m_wrs[i] = 1;
            if (wa && bus_wdata[2]) m_wds[i] = 0; else if (expire) m_wds[i] = 1;
            m_rst[i] = (i == 0) ? fire : (m_rst[i] || fire);
            m_cnt[i] = (!run || svc) ? 0 : (m_cnt[i] + 1) % (LAST + 1);
            m_start[i] = m_start[i] || run;
            if (wa) m_ena[i] = bus_wdata[1] || (lock && m_ena[i]);
            if (wb) m_enb[i] = bus_wdata[0] || (lock && m_enb[i]);
         end
      end
   end

   function automatic logic [31:0] m_read(int i);
      int w;
      w = int'(bus_addr) / 4;
      if (w == 0) return {28'd0, m_wrs[i], m_wds[i], m_ena[i], m_enb[i]};
      if (w == 1) return {31'd0, m_enb[i]};
      if (w == 2) return m_tb;
      return 32'd0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic string rd_tag();
      int w;
      w = int'(bus_addr) / 4;
      if (w == 0 || w == 1) return "R2 control read";
      if (w == 2) return "R7 timebase read";
      return "R1 unmapped read";
   endfunction

   // Per-cycle comparison against the reference
   always @(negedge clk) begin
      #1.5;
      if (rst_n && !done) begin
         chk({rd_tag(), " u0"}, rd0, m_read(0));
         chk({rd_tag(), " u1"}, rd1, m_read(1));
         chk("R4 irq u0", {31'd0, irq0}, {31'd0, m_wds[0]});
         chk("R4 irq u1", {31'd0, irq1}, {31'd0, m_wds[1]});
         chk("R5/R8 rst u0", {31'd0, rst0}, {31'd0, m_rst[0]});
         chk("R5/R8 rst u1", {31'd0, rst1}, {31'd0, m_rst[1]});
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
      #0.2;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
      #1.2;
   endtask

   task automatic both(string tag, logic [31:0] a0, logic [31:0] e0,
                       logic [31:0] a1, logic [31:0] e1);
      chk({tag, " u0"}, a0, e0);
      chk({tag, " u1"}, a1, e1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired before the sequence completed");
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v1, v2;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      // R10 reset state
      both("R10 ctrl after reset", rd0, 32'h0, rd1, 32'h0);
      both("R10 irq/rst after reset", {irq0, rst0}, 2'b00, {irq1, rst1}, 2'b00);

      // R1 unmapped word reads zero, writes to it change nothing
      bus_addr = 4'hC; #0.1;
      both("R1 unmapped read", rd0, 32'h0, rd1, 32'h0);
      wr(4'hC, 32'hFFFF_FFFF);
      both("R1 unmapped write", rd0, 32'h0, rd1, 32'h0);

      // R2 bit 0 of word 0 is a read-only copy
      wr(4'h0, 32'h1);
      both("R2 mirror not writable", rd0, 32'h0, rd1, 32'h0);
      wr(4'h0, 32'h2);
      both("R2 enable A field", rd0, 32'h2, rd1, 32'h2);

      // R3 a single enable does not run the interval
      cyc(40);
      both("R3 one enable idle", {irq0, rst0}, 2'b00, {irq1, rst1}, 2'b00);

      // R7 timebase steps by one per cycle, writes ignored
      bus_addr = 4'h8; #0.1; v1 = rd0;
      cyc(1); bus_addr = 4'h8; #0.1; v2 = rd0;
      chk("R7 timebase step", v2 - v1, 32'd1);
      wr(4'h8, 32'h0);
      bus_addr = 4'h8; #0.1; v1 = rd1;
      cyc(1); bus_addr = 4'h8; #0.1; v2 = rd1;
      chk("R7 timebase after write", v2 - v1, 32'd1);
      chk("R7 timebase not cleared", {31'd0, v1 > 32'd40}, 32'd1);
      bus_addr = 4'h0; #0.1;

      // R3/R4 both enables: first expiry after 2^EXP running cycles
      wr(4'h4, 32'h1);
      both("R2 both enables", rd0, 32'h3, rd1, 32'h3);
      cyc(LAST);
      both("R4 no irq one cycle early", {31'd0, irq0}, 0, {31'd0, irq1}, 0);
      cyc(1);
      both("R4 irq at first expiry", {31'd0, irq0}, 1, {31'd0, irq1}, 1);
      both("R4 state flag set", rd0, 32'h7, rd1, 32'h7);

      // R5 second expiry raises reset
      cyc(LAST);
      both("R5 no reset one cycle early", {31'd0, rst0}, 0, {31'd0, rst1}, 0);
      cyc(1);
      both("R5 reset at second expiry", {31'd0, rst0}, 1, {31'd0, rst1}, 1);
      both("R5 reset-status set", rd0, 32'hF, rd1, 32'hF);
      cyc(1);
      chk("R8 pulse mode drops u0", {31'd0, rst0}, 0);
      chk("R8 hold mode stays u1", {31'd0, rst1}, 1);
      chk("R8 status survives request u0", rd0, 32'hF);

      // R6 service clears flags and restarts the interval
      wr(4'h0, 32'hE);
      both("R6 flags cleared", rd0, 32'h3, rd1, 32'h3);
      both("R6 irq cleared", {31'd0, irq0}, 0, {31'd0, irq1}, 0);
      chk("R8 hold survives service u1", {31'd0, rst1}, 1);
      cyc(LAST);
      // service on the very edge of a pending expiry wins
      wr(4'h0, 32'h6);
      both("R6 service beats expiry", {31'd0, irq0}, 0, {31'd0, irq1}, 0);
      cyc(LAST);
      both("R6 restarted interval early", {31'd0, irq0}, 0, {31'd0, irq1}, 0);
      cyc(1);
      both("R6 restarted interval expiry", {31'd0, irq0}, 1, {31'd0, irq1}, 1);

      // R9 disable attempts
      wr(4'h0, 32'h4);
      wr(4'h4, 32'h0);
      chk("R9 free enables cleared u0", rd0, 32'h0);
      chk("R9 locked enables kept u1", rd1, 32'h3);
      bus_addr = 4'h4; #0.1;
      both("R2 word 1 enable B", rd0, 32'h0, rd1, 32'h1);
      bus_addr = 4'h0; #0.1;
      cyc(2 * (LAST + 1) + 2);
      chk("R3 stopped watchdog quiet u0", {29'd0, irq0, rst0, rd0[3]}, 3'b000);
      chk("R9 locked watchdog still runs u1", {31'd0, irq1}, 1);

      // R8/R10 system reset ends the held request
      rst_n = 1'b0; #0.5;
      chk("R8 hold released by reset u1", {31'd0, rst1}, 0);
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      both("R10 ctrl after second reset", rd0, 32'h0, rd1, 32'h0);
      both("R10 irq after second reset", {31'd0, irq0}, 0, {31'd0, irq1}, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule